// File: doc/BRIEF.md
# Rising-Edge Interrupt Cause Collector

This block turns a vector of level status flags coming from a peripheral into a single interrupt request. Each flag is compared with its value from the previous clock. When a flag goes from low to high, the matching cause bit is latched. A flag that simply stays high does not latch its cause bit again. Software clears a cause bit by writing a one to it, and it enables interrupt sources through a mask register. The interrupt output is asserted while any latched cause bit has its mask bit set.

Cause bits are latched whether or not they are masked. Unmasking a pending cause therefore raises the interrupt at once. A flag that was already high before it was unmasked, and whose cause was cleared, raises nothing until the flag falls and rises again. A rising flag takes priority over a clear written in the same cycle, so an edge is never lost. The request output is combinational from the registers by default; a parameter adds a register stage on the output.

Top module: `irq_edge_collect`

## Requirements
- R1: When status bit i is 0 in one sampled cycle and 1 in the next, cause bit i reads 1 after that clock edge.
- R2: A status bit that stays 1 does not set its cause bit again after that bit has been cleared.
- R3: A write to the cause register (cause_wr high) clears exactly the cause bits where wr_data is 1. Bits where wr_data is 0 keep their value.
- R4: A cause write with wr_data all ones clears every cause bit that is not rising in that cycle.
- R5: If a status bit rises in the same cycle that its cause bit is written with 1, the cause bit stays 1.
- R6: A mask write (mask_wr high) loads wr_data into the mask register, and the mask holds otherwise. With the mask all zero, irq stays low.
- R7: irq equals the OR of all bits of (cause AND mask). With the default IRQ_REG=0 this holds in the same cycle the registers change.
- R8: Cause bits latch while masked. A mask write that covers a pending cause raises irq right after that write.
- R9: Reset clears the cause and mask registers and irq. The stored previous-status value is 0 during reset, so a flag that is already high when reset ends is treated as a rising edge at the first clock edge.
- R10: A falling status bit neither sets nor clears its cause bit.
- R11: rd_data returns the cause register when rd_sel is 0 and the mask register when rd_sel is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | NUM_SRC | Level status flags |
| cause_wr | input | 1 | Write-one-to-clear strobe for the cause register |
| mask_wr | input | 1 | Load strobe for the mask register |
| wr_data | input | NUM_SRC | Write data shared by both registers |
| rd_sel | input | 1 | Read select: 0 for cause, 1 for mask |
| rd_data | output | NUM_SRC | Selected register contents |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with NUM_SRC=12 and IRQ_REG=0. The width is not a power of two, so a wrong bit slice or a vector shortened to a byte shows up in the upper flags. The combinational output variant makes it possible to check unmask-to-irq in the same cycle as the write. It also allows a same-edge rise and clear to be checked bit by bit. Random flag toggles mixed with overlapping clears and mask loads reach a rise, a fall and a clear landing on the same bit together.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;
   typedef enum logic {
      RD_CAUSE = 1'b0,
      RD_MASK  = 1'b1
   } rd_sel_e;

   localparam int unsigned MAX_SRC = 64;
endpackage

// File: rtl/ieu_rise_detect.sv
module ieu_rise_detect #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] status_i,
   output logic [W-1:0] prev_o,
   output logic [W-1:0] rise_o
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= status_i;
   end

   assign prev_o = prev_q;
   assign rise_o = status_i & ~prev_q;
endmodule

// File: rtl/ieu_cause_bank.sv
module ieu_cause_bank #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_en_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] cause_o
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   bit_q <= 1'b0;
         else if (set_i[b])            bit_q <= 1'b1;
         else if (clr_en_i && clr_i[b]) bit_q <= 1'b0;
      end
      assign cause_o[b] = bit_q;
   end
endmodule

// File: rtl/ieu_irq_merge.sv
module ieu_irq_merge #(
   parameter int unsigned W       = 8,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cause_i,
   input  logic [W-1:0] mask_i,
   output logic         irq_o
);
   logic any_pend;
   assign any_pend = |(cause_i & mask_i);

   if (REG_OUT) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= any_pend;
      end
      assign irq_o = irq_q;
   end else begin : g_comb
      assign irq_o = any_pend;
   end
endmodule

// File: rtl/irq_edge_collect.sv
module irq_edge_collect #(
   parameter int unsigned NUM_SRC = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] status_i,
   input  logic               cause_wr,
   input  logic               mask_wr,
   input  logic [NUM_SRC-1:0] wr_data,
   input  logic               rd_sel,
   output logic [NUM_SRC-1:0] rd_data,
   output logic               irq_o
);
   import irq_edge_pkg::*;

   if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_width
      $error("irq_edge_collect: NUM_SRC out of range");
   end

   logic [NUM_SRC-1:0] prev_q;
   logic [NUM_SRC-1:0] rise;
   logic [NUM_SRC-1:0] cause_q;
   logic [NUM_SRC-1:0] mask_q;

   ieu_rise_detect #(.W(NUM_SRC)) u_rise (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (status_i),
      .prev_o   (prev_q),
      .rise_o   (rise)
   );

   ieu_cause_bank #(.W(NUM_SRC)) u_cause (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (rise),
      .clr_en_i (cause_wr),
      .clr_i    (wr_data),
      .cause_o  (cause_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_wr) mask_q <= wr_data;
   end

   ieu_irq_merge #(.W(NUM_SRC), .REG_OUT(IRQ_REG)) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .cause_i (cause_q),
      .mask_i  (mask_q),
      .irq_o   (irq_o)
   );

   always_comb begin
      unique case (rd_sel_e'(rd_sel))
         RD_MASK:  rd_data = mask_q;
         default:  rd_data = cause_q;
      endcase
   end
endmodule

// File: rtl/irq_edge_collect_chk.sv
module irq_edge_collect_chk #(
   parameter int unsigned W       = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] rise,
   input logic [W-1:0] cause_q,
   input logic [W-1:0] mask_q,
   input logic         cause_wr,
   input logic         mask_wr,
   input logic [W-1:0] wr_data,
   input logic         irq_o
);
   // R1, R5: a rising flag always leaves its cause bit set
   assert_rise_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cause_q & $past(rise)) == $past(rise)));

   // R2, R10: a cause bit never turns on without a rise
   assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(rise)) == '0));

   // R3: written ones without a rise are cleared
   assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cause_wr |=> ((cause_q & $past(wr_data & ~rise)) == '0));

   // R6: the mask holds without a write
   assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr |=> $stable(mask_q));

   if (IRQ_REG) begin : g_reg
      assert_irq_or_R7: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq_o == $past(|(cause_q & mask_q))));
      assert_mask_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (mask_q == '0) |=> !irq_o);
   end else begin : g_comb
      assert_irq_or_R7: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o == |(cause_q & mask_q));
      assert_mask_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (mask_q == '0) |-> !irq_o);
   end
endmodule

bind irq_edge_collect irq_edge_collect_chk #(.W(NUM_SRC), .IRQ_REG(IRQ_REG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rise     (rise),
   .cause_q  (cause_q),
   .mask_q   (mask_q),
   .cause_wr (cause_wr),
   .mask_wr  (mask_wr),
   .wr_data  (wr_data),
   .irq_o    (irq_o)
);

// File: tb/irq_edge_collect_tb.sv
`timescale 1ns/1ps
module irq_edge_collect_tb;
   localparam int unsigned W = 12;
   localparam logic [W-1:0] ONES = '1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] status_i = '0;
   logic         cause_wr = 1'b0;
   logic         mask_wr = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         rd_sel = 1'b0;
   logic [W-1:0] rd_data;
   logic         irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [W-1:0] m_prev = '0, m_cause = '0, m_mask = '0;

   always #2.5 clk = ~clk;

   irq_edge_collect #(.NUM_SRC(W), .IRQ_REG(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .status_i(status_i), .cause_wr(cause_wr),
      .mask_wr(mask_wr), .wr_data(wr_data), .rd_sel(rd_sel),
      .rd_data(rd_data), .irq_o(irq_o)
   );

   function automatic logic [W-1:0] next_cause(input logic [W-1:0] c, p, s,
                                               input logic cwe,
                                               input logic [W-1:0] d);
      return (c & ~(cwe ? d : '0)) | (s & ~p);
   endfunction

   task automatic chk(input string req, input logic [W-1:0] act, exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      rd_sel = 1'b0; #0.5;
      chk({req, " cause (R11)"}, rd_data, m_cause);
      rd_sel = 1'b1; #0.5;
      chk({req, " mask (R11)"}, rd_data, m_mask);
      chk({req, " irq (R7)"}, W'(irq_o), W'(|(m_cause & m_mask)));
   endtask

   task automatic tick(input logic [W-1:0] st, input logic cwe, mwe,
                       input logic [W-1:0] d);
      status_i = st; cause_wr = cwe; mask_wr = mwe; wr_data = d;
      @(posedge clk);
      if (rst_n) begin
         m_cause = next_cause(m_cause, m_prev, st, cwe, d);
         m_prev  = st;
         if (mwe) m_mask = d;
      end
      @(negedge clk);
      cause_wr = 1'b0; mask_wr = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] st;
      void'($urandom(32'h5EED));
      @(negedge clk);
      st = 12'h005;
      tick(st, 1'b1, 1'b1, ONES);
      tick(st, 1'b0, 0, '0);
      check_all("R9 in reset");
      rst_n = 1'b1;
      tick(st, 1'b0, 1'b0, '0);
      check_all("R9 high flag at release");
      tick(st, 1'b1, 1'b0, ONES);
      check_all("R4 clear all");
      tick(st, 1'b0, 1'b0, '0);
      check_all("R2 steady high");
      st = st | 12'h810;
      tick(st, 1'b0, 1'b0, '0);
      check_all("R1 R8 masked rise");
      tick(st, 1'b0, 1'b1, 12'h010);
      check_all("R8 unmask pending");
      chk("R8 irq after unmask", W'(irq_o), W'(1));
      st = st | 12'h300;
      tick(st, 1'b0, 1'b0, '0);
      tick(st, 1'b1, 1'b0, 12'h100);
      check_all("R3 partial clear");
      st = st & ~12'h100;
      tick(st, 1'b0, 1'b0, '0);
      check_all("R10 falling flag");
      st = st | 12'h100;
      tick(st, 1'b1, 1'b0, 12'h100);
      check_all("R5 rise beats clear");
      tick(st, 1'b0, 1'b1, '0);
      check_all("R6 mask zero");
      chk("R6 irq low", W'(irq_o), W'(0));
      for (int i = 0; i < 3000; i++) begin
         logic [W-1:0] flip, d;
         logic cwe, mwe;
         flip = W'($urandom()) & W'($urandom()) & W'($urandom());
         st  = st ^ flip;
         d   = W'($urandom());
         cwe = ($urandom() % 4) == 0;
         mwe = ($urandom() % 6) == 0;
         tick(st, cwe, mwe, d);
         check_all("R7 random");
      end
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule